// File: doc/BRIEF.md
# Strobed Watchdog Down-Counter

This block is a software watchdog. It is driven by a slow time base of 32 ticks per second, and each tick reaches it as a one-cycle enable on the system clock. A counter holds the number of ticks that remain. Software keeps the system alive by writing a byte with the strobe bit set, and that write reloads the counter. If software stops strobing, the counter reaches zero. At that point the block emits a one-cycle timeout pulse for a downstream interrupt block and sets a sticky flag. The flag stays set until the flags register is read.

The control byte has three fields:

- bit 7 is the strobe. It clears itself and always reads back as 0.
- bit 6 is a lock that protects the timeout field.
- bits 5..0 are the timeout multiplier. One count lasts one tick (31.25 ms), so the range runs from about 31 ms to about 2 s.

With the lock set, software can strobe without having to rewrite the timeout. A reload request is held pending and is applied on the next counting tick after the write. A timeout of 0 switches the watchdog off. Ticks count only while the oscillator-running input is high.

Top module: `wdog_strobe_timer`

## Requirements
- R1: After reset the counter holds RST_TMO (default 63), the lock holds RST_LOCK (default 0), rd_data_o reads {0, lock, timeout}, flag_o and timeout_o are 0, and counting starts at once, so the first timeout comes on the RST_TMO-th tick.
- R2: Each tick taken while osc_run_i is high decrements the counter by one. When a tick moves the counter from 1 to 0, timeout_o is high for exactly the one clock cycle after that tick's clock edge.
- R3: While osc_run_i is low, ticks are ignored. A reload that is pending stays pending until the first tick taken with the oscillator running.
- R4: A timeout field of 0 disables the watchdog: no pulse occurs and the flag is not set, however many ticks arrive.
- R5: A write with bit 7 set requests a reload. The reload happens on the first counting tick after the write cycle, in place of that tick's decrement. Bit 7 always reads back as 0.
- R6: Bit 6 of every write is stored as the lock. While the stored lock is 1 (the value from an earlier write), bits 5..0 of a write are ignored.
- R7: A write that is accepted into the timeout field (lock 0) also requests a reload, even when bit 7 is 0.
- R8: The flag is set together with the timeout pulse and cleared by flags_rd_i. If a new expiry and a read fall in the same cycle, the flag stays set.
- R9: After an expiry the counter rests at 0 and gives no further pulse until a reload.
- R10: If a strobe write and a flags read fall in the same cycle, both take effect: the flag clears and the reload is scheduled.
- R11: A write with bit 7 at 0 while the lock is 1 leaves the count sequence untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 32 Hz tick enable |
| osc_run_i | input | 1 | High while the time base oscillator runs |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Control byte: strobe, lock, timeout |
| flags_rd_i | input | 1 | Read strobe of the flags register; clears the flag |
| rd_data_o | output | 8 | Read-back of the control byte |
| flag_o | output | 1 | Sticky timeout flag |
| timeout_o | output | 1 | One-cycle timeout event |

## Verification
The assertions take tick_i to be a single-cycle pulse with idle cycles between pulses, as a divided time base produces it. They also take writes and flags reads to be single-cycle strobes that are synchronous to clk. The stimulus always separates ticks by at least one idle cycle. It drives every strobe for exactly one cycle, from the falling edge. It lets a write, a flags read and a tick coincide only on purpose, to probe the same-cycle ordering rules.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int WDT_TMO_W = 6;
  localparam int WDT_REG_W = WDT_TMO_W + 2;
  localparam int WDT_STB_BIT = WDT_REG_W - 1;
  localparam int WDT_LCK_BIT = WDT_REG_W - 2;

  typedef logic [WDT_TMO_W-1:0] tmo_t;
  typedef logic [WDT_REG_W-1:0] reg_t;

  // A write asks for a reload when it strobes or when the timeout field is open.
  function automatic logic wdt_reload_request(input logic wr, input reg_t data,
                                              input logic locked);
    return wr & (data[WDT_STB_BIT] | ~locked);
  endfunction

  // Next count for a counting tick: a pending reload wins over the decrement.
  function automatic tmo_t wdt_next_count(input tmo_t cnt, input tmo_t tmo,
                                          input logic go, input logic pend);
    tmo_t nxt;
    nxt = cnt;
    if (go) begin
      if (pend) nxt = tmo;
      else if (cnt != '0) nxt = cnt - tmo_t'(1);
    end
    return nxt;
  endfunction

  // Expiry happens on the tick that takes the counter from one to zero.
  function automatic logic wdt_expires(input tmo_t cnt, input tmo_t tmo,
                                       input logic go, input logic pend);
    return go & ~pend & (cnt == tmo_t'(1)) & (tmo != '0);
  endfunction

  function automatic reg_t wdt_readback(input logic locked, input tmo_t tmo);
    return {1'b0, locked, tmo};
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter tmo_t RST_TMO = tmo_t'(63),
  parameter logic RST_LOCK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  reg_t wr_data,
  input  logic tick_go,
  output tmo_t tmo_q,
  output logic lock_q,
  output logic pend_q
);

  logic req;
  assign req = wdt_reload_request(wr_en, wr_data, lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= RST_TMO;
      lock_q <= RST_LOCK;
      pend_q <= 1'b0;
    end else begin
      if (wr_en) begin
        lock_q <= wr_data[WDT_LCK_BIT];
        if (!lock_q) tmo_q <= wr_data[WDT_TMO_W-1:0];
      end
      pend_q <= req | (pend_q & ~tick_go);
    end
  end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
  import wdt_pkg::*;
#(
  parameter tmo_t RST_TMO = tmo_t'(63)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_go,
  input  logic pend,
  input  tmo_t tmo,
  output tmo_t cnt_q,
  output logic expire
);

  assign expire = wdt_expires(cnt_q, tmo, tick_go, pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_TMO;
    else        cnt_q <= wdt_next_count(cnt_q, tmo, tick_go, pend);
  end

endmodule

// File: rtl/wdt_event_flag.sv
module wdt_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic flags_rd,
  output logic flag_q,
  output logic pulse_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire;
      flag_q  <= expire | (flag_q & ~flags_rd);
    end
  end

endmodule

// File: rtl/wdog_strobe_timer.sv
module wdog_strobe_timer
  import wdt_pkg::*;
#(
  parameter tmo_t RST_TMO = tmo_t'(63),
  parameter logic RST_LOCK = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 osc_run_i,
  input  logic                 wr_en_i,
  input  logic [WDT_REG_W-1:0] wr_data_i,
  input  logic                 flags_rd_i,
  output logic [WDT_REG_W-1:0] rd_data_o,
  output logic                 flag_o,
  output logic                 timeout_o
);

  logic tick_go;
  logic lock_q;
  logic pend_q;
  logic expire_evt;
  tmo_t tmo_q;
  tmo_t cnt_q;

  assign tick_go = tick_i & osc_run_i;

  wdt_ctrl_reg #(.RST_TMO(RST_TMO), .RST_LOCK(RST_LOCK)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .tick_go(tick_go), .tmo_q(tmo_q), .lock_q(lock_q), .pend_q(pend_q)
  );

  wdt_down_counter #(.RST_TMO(RST_TMO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_go(tick_go), .pend(pend_q),
    .tmo(tmo_q), .cnt_q(cnt_q), .expire(expire_evt)
  );

  wdt_event_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire_evt), .flags_rd(flags_rd_i),
    .flag_q(flag_o), .pulse_q(timeout_o)
  );

  assign rd_data_o = wdt_readback(lock_q, tmo_q);

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick_go,
  input logic osc_run,
  input logic wr_en,
  input logic flags_rd,
  input tmo_t tmo,
  input logic lock,
  input logic pend,
  input tmo_t cnt,
  input logic expire,
  input logic timeout,
  input logic flag
);

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  p_hold_no_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |=> $stable(cnt));

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo == '0) |=> !timeout);

  p_reload_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && pend) |=> (cnt == $past(tmo)));

  p_lock_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(tmo));

  p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> flag);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !expire) |=> !flag);

  p_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !pend) |=> (cnt == '0));

endmodule

bind wdog_strobe_timer wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_go(tick_go), .osc_run(osc_run_i),
  .wr_en(wr_en_i), .flags_rd(flags_rd_i), .tmo(tmo_q), .lock(lock_q),
  .pend(pend_q), .cnt(cnt_q), .expire(expire_evt), .timeout(timeout_o),
  .flag(flag_o)
);

// File: tb/wdog_strobe_timer_tb.sv
module wdog_strobe_timer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic osc_run_i = 1'b1;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic flags_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic flag_o;
  logic timeout_o;

  int checks = 0;
  int errors = 0;
  int first;
  int npulse;

  always #2.5 clk = ~clk;

  wdog_strobe_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_run_i(osc_run_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flags_rd_i(flags_rd_i),
    .rd_data_o(rd_data_o), .flag_o(flag_o), .timeout_o(timeout_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flags_rd_i = 1'b1;
    @(negedge clk); flags_rd_i = 1'b0;
  endtask

  // Issue n ticks; report the index (1-based) of the first pulse and the pulse count.
  task automatic ticks(input int n, output int first_idx, output int count);
    first_idx = 0;
    count = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      if (timeout_o) begin
        count++;
        if (first_idx == 0) first_idx = i;
      end
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 readback", int'(rd_data_o), 8'h3F);
    check("R1 flag", int'(flag_o), 0);
    check("R1 pulse", int'(timeout_o), 0);
    ticks(70, first, npulse);
    check("R1 R2 first expiry tick", first, 63);
    check("R2 single pulse", npulse, 1);
    check("R8 flag set", int'(flag_o), 1);
    ticks(5, first, npulse);
    check("R9 no repeat", npulse, 0);
    clr_flag();
    check("R8 flag cleared", int'(flag_o), 0);

    // R5 R7 sweep over all nonzero timeouts
    for (int n = 1; n < 64; n++) begin
      wr(8'h80 | 8'(n));
      check("R5 strobe reads 0", int'(rd_data_o), n);
      ticks(n + 3, first, npulse);
      check("R2 R5 ticks to expiry", first, n + 1);
      clr_flag();
    end

    wr(8'h07);
    ticks(12, first, npulse);
    check("R7 field write reloads", first, 8);
    clr_flag();

    wr(8'h45);
    wr(8'h49);
    check("R6 locked field", int'(rd_data_o), 8'h45);
    ticks(10, first, npulse);
    check("R6 timeout", first, 6);

    wr(8'hC5);
    ticks(3, first, npulse);
    wr(8'h54);
    ticks(6, first, npulse);
    check("R11 plain write no effect", first, 3);
    clr_flag();

    osc_run_i = 1'b0;
    wr(8'hC5);
    ticks(10, first, npulse);
    check("R3 halted", npulse, 0);
    osc_run_i = 1'b1;
    ticks(10, first, npulse);
    check("R3 resume", first, 6);
    clr_flag();

    npulse = 0;
    for (int k = 0; k < 10; k++) begin
      int f, c;
      wr(8'hC0);
      ticks(3, f, c);
      npulse += c;
    end
    check("R5 keepalive", npulse, 0);
    check("R5 keepalive flag", int'(flag_o), 0);
    ticks(5, first, npulse);
    check("R5 expiry after stop", first, 3);

    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'hC0; flags_rd_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; flags_rd_i = 1'b0;
    check("R10 flag cleared", int'(flag_o), 0);
    ticks(10, first, npulse);
    check("R10 reload scheduled", first, 6);
    clr_flag();

    wr(8'h01);
    wr(8'hC1);
    ticks(1, first, npulse);
    check("R8 reload tick quiet", npulse, 0);
    @(negedge clk); tick_i = 1'b1; flags_rd_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; flags_rd_i = 1'b0;
    check("R8 pulse on collision", int'(timeout_o), 1);
    check("R8 set wins", int'(flag_o), 1);
    clr_flag();

    wr(8'h00);
    wr(8'h80);
    check("R4 readback", int'(rd_data_o), 0);
    ticks(100, first, npulse);
    check("R4 disabled", npulse, 0);
    check("R4 flag", int'(flag_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule